// File: doc/BRIEF.md
# Programmable Parallel Port with Handshake

This block is a 24-line parallel input/output unit that sits on an 8-bit processor bus. It has three 8-bit ports, A, B and C, and port C is treated as two 4-bit halves. The processor reaches the three ports and a control register through a two-bit address. A register access happens only when the select input is high and exactly one of read or write is high. Each bus input is sampled on the rising clock edge. Read data is registered: it appears one cycle after the access, together with an output-enable for the shared data bus.

The control register sets the direction of port A, port B and each half of port C. It also sets one mode bit. In simple mode every port is plain general-purpose I/O. In strobed mode, three lines of each port C half become handshake lines. The lower half serves port A and the upper half serves port B. In each half, one line is a data-ready strobe from the device, one is an acknowledge to the device, and one is an interrupt request toward the system interrupt controller. For an input port, data is captured on the strobe and the processor is interrupted. For an output port, the strobe tells the block that the device has taken the data.

Top module: `pio24_port`

## Requirements
- R1: After reset every port line is an input (all output enables low), the control register reads 0x0F, every handshake output is low and `rdata_oe` is low.
- R2: Address 00 selects port A, 01 port B, 10 port C and 11 the control register. An access is taken only when `sel` is high and exactly one of `rd`/`wr` is high. Any other combination changes no state and produces no read data.
- R3: Control bit 0 sets port A to input when 1. Bit 1 does the same for port B, bit 2 for the lower half of port C and bit 3 for the upper half. Bit 4 selects strobed mode. Bits 7..5 are stored and read back but have no effect.
- R4: A read returns the live pin value for a port line set to input and the output latch for a line set to output. `rdata` holds this value in the cycle after the access, and `rdata_oe` is high for exactly that one cycle.
- R5: A write loads the addressed port's output latch. A port set to output drives its latch on its pins with all output enables high.
- R6: In strobed mode, port C bit 0 is the port A ready input, bit 1 the port A acknowledge output and bit 2 the port A interrupt output. Bits 4, 5 and 6 play the same roles for port B. Bits 3 and 7 stay general-purpose lines that follow their half's direction bit.
- R7: In strobed input mode, a rising edge on the ready line captures the port pins. Reads of that port return the captured byte, not the live pins.
- R8: In strobed input mode, the interrupt output goes high one cycle after the ready rising edge and stays high until the processor reads that port. The acknowledge output is high for exactly that one cycle after the edge.
- R9: When a read of a strobed input port falls in the same cycle as a ready rising edge, the read returns the previously captured byte and the interrupt stays set.
- R10: In strobed output mode, a write to the port drives the new byte, clears the interrupt and raises acknowledge for one cycle. A ready rising edge sets the interrupt. If a write and a ready edge fall in the same cycle, the write wins and the interrupt is low afterwards.
- R11: A write to the control register clears the interrupt and acknowledge outputs of both ports.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data from the processor |
| rdata | output | 8 | Registered read data |
| rdata_oe | output | 1 | Read data valid / bus drive enable |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A pin outputs |
| pa_oe | output | 8 | Port A per-line output enables |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B pin outputs |
| pb_oe | output | 8 | Port B per-line output enables |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C pin outputs |
| pc_oe | output | 8 | Port C per-line output enables |

## Verification
Two functions can meet in one cycle on a strobed port: the device's ready edge and the processor's access to the same port. The bench provokes both collisions.

For the input case, a read of port A is issued in exactly the cycle in which the ready line rises. The bench then checks that the read returns the byte captured earlier and that the interrupt output stays high. A second read must return the new byte and clear the interrupt.

For the output case, a write and a ready edge are issued together. The bench then checks that the interrupt is low, the new byte is on the pins and the acknowledge output pulses.

// File: rtl/pio_pkg.sv
package pio_pkg;

  typedef enum logic [1:0] {
    SEL_A    = 2'b00,
    SEL_B    = 2'b01,
    SEL_C    = 2'b10,
    SEL_CTRL = 2'b11
  } pio_sel_e;

  localparam int unsigned CW_BITS = 5;

  // control word, bit 0 (dir_a) through bit 4 (strobed)
  typedef struct packed {
    logic strobed;
    logic dir_chi;
    logic dir_clo;
    logic dir_b;
    logic dir_a;
  } pio_cw_t;

  localparam logic [CW_BITS-1:0] CW_RESET = 5'b01111;

  // handshake line positions inside one port C half
  localparam int unsigned HS_RDY = 0;
  localparam int unsigned HS_ACK = 1;
  localparam int unsigned HS_IRQ = 2;

endpackage

// File: rtl/pio_busif.sv
module pio_busif
  import pio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic         rd,
  input  logic         wr,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] rd_a,
  input  logic [W-1:0] rd_b,
  input  logic [W-1:0] rd_c,
  output logic [3:0]   rd_hit,
  output logic [3:0]   wr_hit,
  output pio_cw_t      cw,
  output logic         cw_wr,
  output logic [W-1:0] rdata,
  output logic         rdata_oe
);

  logic         acc_ok;
  logic         rd_en;
  logic [W-1:0] cw_q, cw_d;
  logic [W-1:0] rmux;
  logic [W-1:0] rdata_q;
  logic         oe_q;

  assign acc_ok = sel & (rd ^ wr);
  assign rd_en  = acc_ok & rd;

  always_comb begin
    rd_hit = '0;
    wr_hit = '0;
    if (acc_ok) begin
      if (rd) rd_hit[addr] = 1'b1;
      else    wr_hit[addr] = 1'b1;
    end
  end

  assign cw_wr = wr_hit[SEL_CTRL];

  always_comb begin
    cw_d = cw_q;
    if (cw_wr) cw_d = wdata;
  end

  always_comb begin
    unique case (pio_sel_e'(addr))
      SEL_A:   rmux = rd_a;
      SEL_B:   rmux = rd_b;
      SEL_C:   rmux = rd_c;
      default: rmux = cw_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cw_q    <= W'(CW_RESET);
      rdata_q <= '0;
      oe_q    <= 1'b0;
    end else begin
      cw_q <= cw_d;
      oe_q <= rd_en;
      if (rd_en) rdata_q <= rmux;
    end
  end

  assign cw       = pio_cw_t'(cw_q[CW_BITS-1:0]);
  assign rdata    = rdata_q;
  assign rdata_oe = oe_q;

endmodule

// File: rtl/pio_hs_port.sv
module pio_hs_port #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobed,
  input  logic         is_in,
  input  logic [W-1:0] pin_in,
  input  logic         rdy_pin,
  input  logic         acc_rd,
  input  logic         acc_wr,
  input  logic         cw_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] rd_val,
  output logic         ack,
  output logic         irq
);

  logic         rdy_q;
  logic         rise;
  logic [W-1:0] out_q, out_d;
  logic [W-1:0] buf_q, buf_d;
  logic         irq_q, irq_d;
  logic         ack_q, ack_d;
  logic         cap_en;

  assign rise   = strobed & rdy_pin & ~rdy_q;
  assign cap_en = rise & is_in;

  always_comb begin
    out_d = out_q;
    if (acc_wr) out_d = wdata;
  end

  always_comb begin
    buf_d = buf_q;
    if (cap_en) buf_d = pin_in;
  end

  always_comb begin
    irq_d = irq_q;
    ack_d = 1'b0;
    if (cw_wr || !strobed) begin
      irq_d = 1'b0;
    end else if (is_in) begin
      if (rise)        irq_d = 1'b1;
      else if (acc_rd) irq_d = 1'b0;
      ack_d = rise;
    end else begin
      if (acc_wr)    irq_d = 1'b0;
      else if (rise) irq_d = 1'b1;
      ack_d = acc_wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      out_q <= '0;
      buf_q <= '0;
      irq_q <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      rdy_q <= rdy_pin;
      out_q <= out_d;
      buf_q <= buf_d;
      irq_q <= irq_d;
      ack_q <= ack_d;
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = {W{~is_in}};
  assign rd_val  = is_in ? (strobed ? buf_q : pin_in) : out_q;
  assign ack     = ack_q;
  assign irq     = irq_q;

endmodule

// File: rtl/pio_portc.sv
module pio_portc
  import pio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobed,
  input  logic         dir_clo,
  input  logic         dir_chi,
  input  logic         acc_wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  input  logic         ack_a,
  input  logic         irq_a,
  input  logic         ack_b,
  input  logic         irq_b,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] rd_val,
  output logic         rdy_a,
  output logic         rdy_b
);

  localparam int unsigned HALF = W / 2;

  logic [W-1:0] out_q, out_d;

  always_comb begin
    out_d = out_q;
    if (acc_wr) out_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  for (genvar i = 0; i < W; i++) begin : g_line
    localparam bit          HI  = (i >= HALF);
    localparam int unsigned POS = i % HALF;
    logic base_oe;
    assign base_oe = HI ? ~dir_chi : ~dir_clo;

    if (POS == HS_RDY) begin : g_rdy
      assign pin_oe[i]  = strobed ? 1'b0 : base_oe;
      assign pin_out[i] = out_q[i];
    end else if (POS == HS_ACK) begin : g_ack
      assign pin_oe[i]  = strobed ? 1'b1 : base_oe;
      assign pin_out[i] = strobed ? (HI ? ack_b : ack_a) : out_q[i];
    end else if (POS == HS_IRQ) begin : g_irq
      assign pin_oe[i]  = strobed ? 1'b1 : base_oe;
      assign pin_out[i] = strobed ? (HI ? irq_b : irq_a) : out_q[i];
    end else begin : g_gpio
      assign pin_oe[i]  = base_oe;
      assign pin_out[i] = out_q[i];
    end

    assign rd_val[i] = pin_oe[i] ? pin_out[i] : pin_in[i];
  end

  assign rdy_a = pin_in[HS_RDY];
  assign rdy_b = pin_in[HALF + HS_RDY];

endmodule

// File: rtl/pio24_port.sv
module pio24_port
  import pio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic         rd,
  input  logic         wr,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         rdata_oe,
  input  logic [W-1:0] pa_in,
  output logic [W-1:0] pa_out,
  output logic [W-1:0] pa_oe,
  input  logic [W-1:0] pb_in,
  output logic [W-1:0] pb_out,
  output logic [W-1:0] pb_oe,
  input  logic [W-1:0] pc_in,
  output logic [W-1:0] pc_out,
  output logic [W-1:0] pc_oe
);

  pio_cw_t      cw;
  logic         cw_wr;
  logic [3:0]   rd_hit, wr_hit;
  logic [W-1:0] rd_a, rd_b, rd_c;
  logic         ack_a, irq_a, ack_b, irq_b;
  logic         rdy_a, rdy_b;

  pio_busif #(.W(W)) u_bus (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rd_a(rd_a), .rd_b(rd_b), .rd_c(rd_c),
    .rd_hit(rd_hit), .wr_hit(wr_hit), .cw(cw), .cw_wr(cw_wr),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  pio_hs_port #(.W(W)) u_pa (
    .clk(clk), .rst_n(rst_n), .strobed(cw.strobed), .is_in(cw.dir_a),
    .pin_in(pa_in), .rdy_pin(rdy_a), .acc_rd(rd_hit[SEL_A]),
    .acc_wr(wr_hit[SEL_A]), .cw_wr(cw_wr), .wdata(wdata),
    .pin_out(pa_out), .pin_oe(pa_oe), .rd_val(rd_a), .ack(ack_a), .irq(irq_a)
  );

  pio_hs_port #(.W(W)) u_pb (
    .clk(clk), .rst_n(rst_n), .strobed(cw.strobed), .is_in(cw.dir_b),
    .pin_in(pb_in), .rdy_pin(rdy_b), .acc_rd(rd_hit[SEL_B]),
    .acc_wr(wr_hit[SEL_B]), .cw_wr(cw_wr), .wdata(wdata),
    .pin_out(pb_out), .pin_oe(pb_oe), .rd_val(rd_b), .ack(ack_b), .irq(irq_b)
  );

  pio_portc #(.W(W)) u_pc (
    .clk(clk), .rst_n(rst_n), .strobed(cw.strobed), .dir_clo(cw.dir_clo),
    .dir_chi(cw.dir_chi), .acc_wr(wr_hit[SEL_C]), .wdata(wdata),
    .pin_in(pc_in), .ack_a(ack_a), .irq_a(irq_a), .ack_b(ack_b),
    .irq_b(irq_b), .pin_out(pc_out), .pin_oe(pc_oe), .rd_val(rd_c),
    .rdy_a(rdy_a), .rdy_b(rdy_b)
  );

endmodule

// File: rtl/pio24_port_chk.sv
module pio24_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel,
  input logic       rd,
  input logic       wr,
  input logic [1:0] addr,
  input logic       rdata_oe,
  input logic [7:0] pa_out,
  input logic       rdy_a,
  input logic       ack_a_pin,
  input logic       irq_a_pin,
  input logic [2:0] pc_oe_lo,
  input logic [2:0] pc_oe_hi,
  input logic       strobed,
  input logic       dir_a
);

  // R4: a read produces exactly one cycle of read data
  assert_read_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && rd && !wr) |=> rdata_oe);
  assert_no_oe_without_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && rd && !wr) |=> !rdata_oe);

  // R2: port A latch holds unless a proper write is taken
  assert_no_stray_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && wr && !rd) |=> $stable(pa_out));

  // R6: handshake line directions in strobed mode
  assert_hs_dirs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobed |-> (pc_oe_lo == 3'b110 && pc_oe_hi == 3'b110));

  // R8: a read without a coincident strobe clears the interrupt
  assert_irq_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && strobed && dir_a && sel && rd && !wr && addr == 2'b00
     && !(rdy_a && !$past(rdy_a))) |=> !irq_a_pin);

  // R8: acknowledge is a single-cycle pulse in strobed input mode
  assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobed && dir_a && $past(strobed && dir_a) && ack_a_pin) |=> !ack_a_pin);

endmodule

bind pio24_port pio24_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .rd(rd), .wr(wr), .addr(addr),
  .rdata_oe(rdata_oe), .pa_out(pa_out), .rdy_a(pc_in[0]),
  .ack_a_pin(pc_out[1]), .irq_a_pin(pc_out[2]),
  .pc_oe_lo(pc_oe[2:0]), .pc_oe_hi(pc_oe[6:4]),
  .strobed(cw.strobed), .dir_a(cw.dir_a)
);

// File: tb/tb_pio24_port.sv
module tb_pio24_port;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sel, rd, wr;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  logic       rdata_oe;
  logic [7:0] pa_in, pa_out, pa_oe, pb_in, pb_out, pb_oe, pc_in, pc_out, pc_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pio24_port dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic do_rd(input logic [1:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    sel = 1'b1; rd = 1'b1; addr = a;
    @(negedge clk);
    sel = 1'b0; rd = 1'b0;
    d = rdata; oe = rdata_oe;
  endtask

  function automatic logic [7:0] exp_pc_oe(input logic [4:0] c);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      logic base;
      base = (i >= 4) ? !c[3] : !c[2];
      case (i % 4)
        0:       r[i] = c[4] ? 1'b0 : base;
        1, 2:    r[i] = c[4] ? 1'b1 : base;
        default: r[i] = base;
      endcase
    end
    return r;
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic oe;
    rst_n = 1'b0; sel = 0; rd = 0; wr = 0; addr = 0; wdata = 0;
    pa_in = 0; pb_in = 0; pc_in = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(pa_oe == 0 && pb_oe == 0 && pc_oe == 0, "R1 oe", {pa_oe, pb_oe, pc_oe}, 0);
    check(rdata_oe == 0, "R1 rdata_oe", rdata_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pc_out[2:1] == 0 && pc_out[6:5] == 0, "R1 handshake", pc_out, 0);
    do_rd(2'b11, d, oe);
    check(d == 8'h0F, "R1 ctrl", d, 8'h0F);
    check(oe == 1'b1, "R4 oe", oe, 1);
    @(negedge clk);
    check(rdata_oe == 1'b0, "R4 oe single", rdata_oe, 0);

    // R3 control word sweep with upper bits set
    for (int c = 0; c < 32; c++) begin
      logic [7:0] cwv;
      cwv = 8'(c) | 8'hE0;
      do_wr(2'b11, cwv);
      do_rd(2'b11, d, oe);
      check(d == cwv, "R3 readback", d, cwv);
      check(pa_oe == {8{!cwv[0]}}, "R3 pa_oe", pa_oe, {8{!cwv[0]}});
      check(pb_oe == {8{!cwv[1]}}, "R3 pb_oe", pb_oe, {8{!cwv[1]}});
      check(pc_oe == exp_pc_oe(cwv[4:0]), "R3 R6 pc_oe", pc_oe, exp_pc_oe(cwv[4:0]));
    end

    // R5 R4 simple mode, all outputs
    do_wr(2'b11, 8'h00);
    for (int v = 0; v < 256; v++) begin
      do_wr(2'b00, 8'(v));
      do_wr(2'b01, ~8'(v));
      do_wr(2'b10, 8'(v) ^ 8'h5A);
      check(pa_out == 8'(v) && pa_oe == 8'hFF, "R5 pa", pa_out, v);
      check(pb_out == ~8'(v), "R5 pb", pb_out, ~8'(v));
      check(pc_out == (8'(v) ^ 8'h5A) && pc_oe == 8'hFF, "R5 pc", pc_out, 8'(v) ^ 8'h5A);
      do_rd(2'b00, d, oe);
      check(d == 8'(v), "R4 read latch", d, v);
    end

    // R2 ignored accesses
    @(negedge clk); sel = 0; wr = 1; addr = 0; wdata = 8'h12;
    @(negedge clk); wr = 0;
    check(pa_out == 8'hFF, "R2 no sel", pa_out, 8'hFF);
    @(negedge clk); sel = 1; rd = 1; wr = 1; addr = 0; wdata = 8'h34;
    @(negedge clk); sel = 0; rd = 0; wr = 0;
    check(pa_out == 8'hFF && rdata_oe == 0, "R2 rd and wr", {pa_out, 7'b0, rdata_oe}, 16'hFF00);
    do_wr(2'b01, 8'h56);
    check(pa_out == 8'hFF && pb_out == 8'h56, "R2 decode", {pa_out, pb_out}, 16'hFF56);

    // R4 simple mode, all inputs
    do_wr(2'b11, 8'h0F);
    for (int v = 0; v < 256; v++) begin
      pa_in = 8'(v); pb_in = 8'(v * 3); pc_in = 8'(v) ^ 8'hEE;
      do_rd(2'b00, d, oe);
      check(d == 8'(v), "R4 pa pins", d, v);
      do_rd(2'b01, d, oe);
      check(d == 8'(v * 3), "R4 pb pins", d, 8'(v * 3));
      do_rd(2'b10, d, oe);
      check(d == (8'(v) ^ 8'hEE), "R4 pc pins", d, 8'(v) ^ 8'hEE);
    end

    // R4 split port C: lower input, upper output
    do_wr(2'b11, 8'h04);
    do_wr(2'b10, 8'hA5);
    pc_in = 8'h3C;
    do_rd(2'b10, d, oe);
    check(d == 8'hAC, "R4 pc halves", d, 8'hAC);

    // R7 R8 strobed input on A and B
    pc_in = 8'h00;
    do_wr(2'b11, 8'h13);
    pa_in = 8'h3C;
    @(negedge clk); pc_in[0] = 1'b1;
    @(negedge clk);
    check(pc_out[2] == 1'b1, "R8 irq A set", pc_out[2], 1);
    check(pc_out[1] == 1'b1, "R8 ack A pulse", pc_out[1], 1);
    pa_in = 8'hFF;
    @(negedge clk);
    check(pc_out[1] == 1'b0 && pc_out[2] == 1'b1, "R8 ack A drop", pc_out[2:1], 2'b10);
    do_rd(2'b00, d, oe);
    check(d == 8'h3C, "R7 captured A", d, 8'h3C);
    check(pc_out[2] == 1'b0, "R8 irq A clear", pc_out[2], 0);
    pb_in = 8'h81;
    @(negedge clk); pc_in[4] = 1'b1;
    @(negedge clk);
    check(pc_out[6:5] == 2'b11, "R8 B irq ack", pc_out[6:5], 2'b11);
    pb_in = 8'h00;
    do_rd(2'b01, d, oe);
    check(d == 8'h81, "R7 captured B", d, 8'h81);
    check(pc_out[6] == 1'b0, "R8 irq B clear", pc_out[6], 0);

    // R9 read meets ready edge
    @(negedge clk); pc_in[0] = 1'b0; pa_in = 8'h11;
    @(negedge clk); pc_in[0] = 1'b1;
    @(negedge clk); pc_in[0] = 1'b0;
    @(negedge clk); pa_in = 8'h22; pc_in[0] = 1'b1; sel = 1; rd = 1; addr = 0;
    @(negedge clk); sel = 0; rd = 0;
    check(rdata == 8'h11, "R9 old data", rdata, 8'h11);
    check(pc_out[2] == 1'b1, "R9 irq kept", pc_out[2], 1);
    do_rd(2'b00, d, oe);
    check(d == 8'h22 && pc_out[2] == 1'b0, "R9 second read", {d, 7'b0, pc_out[2]}, 16'h2200);

    // R10 strobed output
    pc_in = 8'h00;
    do_wr(2'b11, 8'h10);
    do_wr(2'b00, 8'h77);
    check(pa_out == 8'h77 && pa_oe == 8'hFF, "R10 data", pa_out, 8'h77);
    check(pc_out[2:1] == 2'b01, "R10 ack pulse", pc_out[2:1], 2'b01);
    @(negedge clk);
    check(pc_out[1] == 1'b0, "R10 ack drop", pc_out[1], 0);
    pc_in[0] = 1'b1;
    @(negedge clk);
    check(pc_out[2] == 1'b1, "R10 irq on ready", pc_out[2], 1);
    pc_in[0] = 1'b0;
    do_wr(2'b00, 8'h44);
    check(pc_out[2] == 1'b0, "R10 write clears", pc_out[2], 0);
    @(negedge clk); pc_in[0] = 1'b1; sel = 1; wr = 1; addr = 0; wdata = 8'h99;
    @(negedge clk); sel = 0; wr = 0;
    check(pc_out[2] == 1'b0 && pa_out == 8'h99 && pc_out[1] == 1'b1, "R10 write wins",
          {pa_out, 6'b0, pc_out[2:1]}, 16'h9901);

    // R11 control write clears handshake state
    @(negedge clk); pc_in[0] = 1'b0;
    @(negedge clk); pc_in[0] = 1'b1;
    @(negedge clk);
    check(pc_out[2] == 1'b1, "R11 irq before", pc_out[2], 1);
    do_wr(2'b11, 8'h10);
    check(pc_out[2:1] == 2'b00, "R11 cleared", pc_out[2:1], 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule